// File: doc/BRIEF.md
# Split-precision array multiplier

This block is an unsigned N×N array multiplier (N is 8 by default and 16 is also supported) whose cells can be enabled or disabled one by one. One control vector runs along the multiplicand bits and one runs along the multiplier bits. The cell that forms the product of multiplicand bit i and multiplier bit j takes part only when the two control bits that reach it differ. Switched-off cells add nothing, and the sum and carry they receive flow on to the next row.

With every column bit set and every row bit clear, the array computes the ordinary full product. Setting the columns at and above a split point P and the rows below P carves the array into two independent multipliers that work side by side. The low one is A[P-1:0]×B[P-1:0] and the high one is A[N-1:P]×B[N-1:P]. Their products sit in adjacent fields of one 2N-bit result word. P may be the midpoint or any uneven point.

The array itself is combinational. Its carry-save rows and the final carry-propagate adder feed a single output register with an asynchronous active-low reset.

Top module: `split_array_mul`

## Requirements
- R1: While rst_ni is low, prod_o is zero whatever the other inputs are.
- R2: One clock edge after a, b, v, h are presented, prod_o equals the sum, over every pair (i, j) with v_i[i] != h_i[j], of a_i[i]·b_i[j]·2^(i+j). Column control v_i[i] pairs with operand bit a_i[i], and row control h_i[j] pairs with operand bit b_i[j].
- R3: With v_i all ones and h_i all zeros, or with v_i all zeros and h_i all ones, prod_o is the full unsigned product a_i×b_i.
- R4: prod_o is zero when v_i and h_i are both all zeros, when they are both all ones, or when either operand is zero.
- R5: With P = N/2, v_i = ones at bits [N-1:P] and zeros below, and h_i = the complement of v_i, prod_o[2P-1:0] = a_i[P-1:0]×b_i[P-1:0] and prod_o[2N-1:2P] = a_i[N-1:P]×b_i[N-1:P].
- R6: The same field layout holds for any split point 1 ≤ P ≤ N-1. Example, N=8 and P=2: a=0x0A and b=0x07 give 0x0026.
- R7: In a split, changing only the upper operand slices leaves prod_o[2P-1:0] unchanged.
- R8: The all-ones by all-ones full product, (2^N-1)², is exact, including the longest carry chain.
- R9: Inverting both v_i and h_i leaves prod_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH_P | Multiplicand; bit i feeds array column i |
| b_i | input | WIDTH_P | Multiplier; bit j feeds array row j |
| v_i | input | WIDTH_P | Column enable controls, one bit per multiplicand bit |
| h_i | input | WIDTH_P | Row enable controls, one bit per multiplier bit |
| prod_o | output | 2*WIDTH_P | Registered product word: the full product or two packed sub-products |

## Verification
The hardest case to provoke is a carry or partial-product term crossing the boundary between the two partitions. Such a leak shows up only when both slices are large and the low partition's carry-out lands right on the field edge. To reach it, the stimulus holds the low slices fixed while it randomises the upper slices at random split points. It also drives the all-ones operands through a split, so that each sub-product fills its field. Arbitrary control vectors, which match no clean partition, are checked against a per-bit reference sum. This covers cells whose enables come in irregular patterns.

// File: rtl/sam_pkg.sv
package sam_pkg;

  typedef struct packed {
    logic s;
    logic c;
  } fa_t;

  function automatic fa_t full_add(input logic x, input logic y, input logic z);
    fa_t r;
    r.s = x ^ y ^ z;
    r.c = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/sam_cell.sv
module sam_cell
  import sam_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic v_i,
  input  logic h_i,
  input  logic sum_i,
  input  logic car_i,
  output logic sum_o,
  output logic car_o
);

  logic en;
  logic pp;
  fa_t  res;

  // cell participates only when its column and row controls differ
  assign en  = v_i ^ h_i;
  assign pp  = a_i & b_i & en;
  assign res = full_add(pp, sum_i, car_i);

  assign sum_o = res.s;
  assign car_o = res.c;

endmodule

// File: rtl/sam_row.sv
module sam_row #(
  parameter int unsigned W = 8,
  parameter int unsigned J = 0
) (
  input  logic [W-1:0]   a_i,
  input  logic           b_bit_i,
  input  logic [W-1:0]   v_i,
  input  logic           h_bit_i,
  input  logic [2*W-1:0] sum_i,
  input  logic [2*W-1:0] car_i,
  output logic [2*W-1:0] sum_o,
  output logic [2*W-1:0] car_o
);

  localparam int unsigned PW = 2 * W;

  logic [W-1:0] cc;

  for (genvar k = 0; k < PW; k++) begin : g_col
    if (k >= J && k < J + W) begin : g_cell
      sam_cell i_cell (
        .a_i   (a_i[k-J]),
        .b_i   (b_bit_i),
        .v_i   (v_i[k-J]),
        .h_i   (h_bit_i),
        .sum_i (sum_i[k]),
        .car_i (car_i[k]),
        .sum_o (sum_o[k]),
        .car_o (cc[k-J])
      );
    end else begin : g_pass
      assign sum_o[k] = sum_i[k];
    end

    if (k == J) begin : g_c_low
      assign car_o[k] = 1'b0;
    end else if (k > J && k < J + W) begin : g_c_cell
      assign car_o[k] = cc[k-J-1];
    end else if (k == J + W) begin : g_c_top
      // incoming slot at this weight is empty: earlier rows never reach it
      assign car_o[k] = cc[W-1] | car_i[k];
    end else begin : g_c_pass
      assign car_o[k] = car_i[k];
    end
  end

endmodule

// File: rtl/sam_cpa.sv
module sam_cpa #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  output logic [PW-1:0] sum_o
);

  logic c;

  always_comb begin
    c = 1'b0;
    for (int k = 0; k < PW; k++) begin
      sum_o[k] = x_i[k] ^ y_i[k] ^ c;
      c        = (x_i[k] & y_i[k]) | (c & (x_i[k] ^ y_i[k]));
    end
  end

endmodule

// File: rtl/split_array_mul.sv
module split_array_mul #(
  parameter int unsigned WIDTH_P = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WIDTH_P-1:0]     a_i,
  input  logic [WIDTH_P-1:0]     b_i,
  input  logic [WIDTH_P-1:0]     v_i,
  input  logic [WIDTH_P-1:0]     h_i,
  output logic [2*WIDTH_P-1:0]   prod_o
);

  localparam int unsigned PW = 2 * WIDTH_P;

  logic [PW-1:0] row_s [WIDTH_P+1];
  logic [PW-1:0] row_c [WIDTH_P+1];
  logic [PW-1:0] prod_d;

  assign row_s[0] = '0;
  assign row_c[0] = '0;

  for (genvar j = 0; j < WIDTH_P; j++) begin : g_row
    sam_row #(
      .W (WIDTH_P),
      .J (j)
    ) i_row (
      .a_i     (a_i),
      .b_bit_i (b_i[j]),
      .v_i     (v_i),
      .h_bit_i (h_i[j]),
      .sum_i   (row_s[j]),
      .car_i   (row_c[j]),
      .sum_o   (row_s[j+1]),
      .car_o   (row_c[j+1])
    );
  end

  sam_cpa #(
    .PW (PW)
  ) i_cpa (
    .x_i   (row_s[WIDTH_P]),
    .y_i   (row_c[WIDTH_P]),
    .sum_o (prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= prod_d;
  end

endmodule

// File: rtl/sam_chk.sv
module sam_chk #(
  parameter int unsigned WIDTH_P = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WIDTH_P-1:0]   a_i,
  input logic [WIDTH_P-1:0]   b_i,
  input logic [WIDTH_P-1:0]   v_i,
  input logic [WIDTH_P-1:0]   h_i,
  input logic [2*WIDTH_P-1:0] prod_o
);

  localparam int unsigned PW = 2 * WIDTH_P;
  localparam int unsigned LW = WIDTH_P / 2;
  localparam int unsigned HW = WIDTH_P - LW;
  localparam logic [WIDTH_P-1:0] HALF_V = {{HW{1'b1}}, {LW{1'b0}}};

  function automatic logic [PW-1:0] pair_sum(input logic [WIDTH_P-1:0] fa, input logic [WIDTH_P-1:0] fb,
                                             input logic [WIDTH_P-1:0] fv, input logic [WIDTH_P-1:0] fh);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < WIDTH_P; i++)
      for (int j = 0; j < WIDTH_P; j++)
        if ((fv[i] != fh[j]) && fa[i] && fb[j]) r = r + (PW'(1) << (i + j));
    return r;
  endfunction

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (prod_o == '0);
  end

  p_pair_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prod_o == $past(pair_sum(a_i, b_i, v_i, h_i)));

  p_full_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((v_i == '1 && h_i == '0) || (v_i == '0 && h_i == '1)) |=>
      prod_o == ({{WIDTH_P{1'b0}}, $past(a_i)} * {{WIDTH_P{1'b0}}, $past(b_i)}));

  p_all_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((v_i == '0 && h_i == '0) || (v_i == '1 && h_i == '1)) |=> prod_o == '0);

  p_zero_operand_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> prod_o == '0);

  p_half_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i == HALF_V && h_i == ~HALF_V) |=>
      prod_o[2*LW-1:0] == ({{LW{1'b0}}, $past(a_i[LW-1:0])} * {{LW{1'b0}}, $past(b_i[LW-1:0])}));

  p_half_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i == HALF_V && h_i == ~HALF_V) |=>
      prod_o[PW-1:2*LW] == ({{HW{1'b0}}, $past(a_i[WIDTH_P-1:LW])} *
                            {{HW{1'b0}}, $past(b_i[WIDTH_P-1:LW])}));

endmodule

bind split_array_mul sam_chk #(.WIDTH_P(WIDTH_P)) i_sam_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .v_i    (v_i),
  .h_i    (h_i),
  .prod_o (prod_o)
);

// File: tb/test_split_array_mul.sv
`timescale 1ns/1ps
module test_split_array_mul;

  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  a, b, v, h;
  logic [PW-1:0] prod;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  split_array_mul #(.WIDTH_P(N)) i_split_array_mul (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .a_i    (a),
    .b_i    (b),
    .v_i    (v),
    .h_i    (h),
    .prod_o (prod)
  );

  always #5 clk = ~clk;

  function automatic logic [PW-1:0] gen_ref(input logic [N-1:0] fa, input logic [N-1:0] fb,
                                            input logic [N-1:0] fv, input logic [N-1:0] fh);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if ((fv[i] != fh[j]) && fa[i] && fb[j]) r = r + (PW'(1) << (i + j));
    return r;
  endfunction

  function automatic logic [PW-1:0] split_ref(input logic [N-1:0] fa, input logic [N-1:0] fb, input int p);
    int unsigned m, lo, hi;
    m  = (1 << p) - 1;
    lo = (32'(fa) & m) * (32'(fb) & m);
    hi = (32'(fa) >> p) * (32'(fb) >> p);
    return PW'((hi << (2 * p)) | lo);
  endfunction

  function automatic logic [N-1:0] low_mask(input int p);
    return N'((1 << p) - 1);
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] ta, input logic [N-1:0] tb,
                       input logic [N-1:0] tv, input logic [N-1:0] th);
    @(negedge clk);
    a = ta; b = tb; v = tv; h = th;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ra, rb, rv, rh, m, alo, blo;
    logic [PW-1:0] fm;
    int p;
    void'($urandom(32'h5eed));
    a = '0; b = '0; v = '0; h = '0;
    repeat (2) @(negedge clk);
    check("R1 reset idle", prod, '0);
    a = '1; b = '1; v = '1; h = '0;
    repeat (3) @(negedge clk);
    check("R1 reset with live inputs", prod, '0);
    a = '0; b = '0;
    rst_ni = 1'b1;

    // R3 full width, stepped multiplicand, both control orientations
    for (int x = 15; x >= 9; x--) begin
      apply(N'(x), N'(9), '1, '0);
      check("R3 cols on", prod, PW'(x * 9));
      apply(N'(x), N'(9), '0, '1);
      check("R3 rows on", prod, PW'(x * 9));
    end
    for (int k = 0; k < 40; k++) begin
      ra = N'($urandom); rb = N'($urandom);
      apply(ra, rb, '1, '0);
      check("R3 random", prod, PW'(32'(ra) * 32'(rb)));
    end

    // R8 longest carry chain
    apply('1, '1, '1, '0);
    check("R8 ones x ones", prod, PW'(((1 << N) - 1) * ((1 << N) - 1)));
    apply('1, '1, '0, '1);
    check("R8 ones x ones rows", prod, PW'(((1 << N) - 1) * ((1 << N) - 1)));

    // R5 even split
    m = low_mask(N / 2);
    apply('1, '1, ~m, m);
    check("R5 ones split", prod, split_ref('1, '1, N / 2));
    for (int k = 0; k < 40; k++) begin
      ra = N'($urandom); rb = N'($urandom);
      apply(ra, rb, ~m, m);
      check("R5 random split", prod, split_ref(ra, rb, N / 2));
    end

    // R6 uneven split
    apply(8'h0A, 8'h07, ~low_mask(2), low_mask(2));
    check("R6 example p2", prod, 16'h0026);
    for (int k = 0; k < 100; k++) begin
      p  = 1 + int'($urandom % (N - 1));
      ra = N'($urandom); rb = N'($urandom);
      if (k % 10 == 0) begin ra = '1; rb = '1; end
      apply(ra, rb, ~low_mask(p), low_mask(p));
      check("R6 random split", prod, split_ref(ra, rb, p));
    end

    // R7 no leakage into the low field
    for (int t = 0; t < 20; t++) begin
      p   = 1 + int'($urandom % (N - 1));
      m   = low_mask(p);
      alo = N'($urandom) & m;
      blo = N'($urandom) & m;
      if (t % 4 == 0) begin alo = m; blo = m; end
      fm  = PW'((1 << (2 * p)) - 1);
      for (int q = 0; q < 4; q++) begin
        ra = (N'($urandom) & ~m) | alo;
        rb = (N'($urandom) & ~m) | blo;
        apply(ra, rb, ~m, m);
        check("R7 low field", prod & fm, PW'(32'(alo) * 32'(blo)));
        check("R7 high field", prod & ~fm, split_ref(ra, rb, p) & ~fm);
      end
    end

    // R2 arbitrary control patterns
    for (int k = 0; k < 150; k++) begin
      ra = N'($urandom); rb = N'($urandom); rv = N'($urandom); rh = N'($urandom);
      apply(ra, rb, rv, rh);
      check("R2 arbitrary", prod, gen_ref(ra, rb, rv, rh));
    end

    // R4 nothing enabled, or a zero operand
    for (int k = 0; k < 10; k++) begin
      ra = N'($urandom) | 1; rb = N'($urandom) | 1;
      apply(ra, rb, '0, '0);
      check("R4 ctrl both zero", prod, '0);
      apply(ra, rb, '1, '1);
      check("R4 ctrl both ones", prod, '0);
      apply('0, rb, N'($urandom), N'($urandom));
      check("R4 a zero", prod, '0);
      apply(ra, '0, N'($urandom), N'($urandom));
      check("R4 b zero", prod, '0);
    end

    // R9 inverting both control vectors
    for (int k = 0; k < 30; k++) begin
      ra = N'($urandom); rb = N'($urandom); rv = N'($urandom); rh = N'($urandom);
      apply(ra, rb, ~rv, ~rh);
      check("R9 inverted ctrl", prod, gen_ref(ra, rb, rv, rh));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule